// File: doc/BRIEF.md
# Program Suspend/Resume Mode Controller

This block tracks an embedded flash program operation as it moves between running, suspended and resumed. It sits behind the bus command decoder of a parallel flash interface. It receives one decoded command code per accepted bus write, a start and a done handshake from the programming engine, and a device-reset pulse. It keeps one mode register. From that register it drives the enable of the programming engine and selects what a read returns: array data, auto-select codes or the one-time-programmable extended block.

While programming is suspended, reads are allowed everywhere except the block being programmed. If an erase was already suspended when programming was suspended, the erase-suspended block is also excluded. A device reset that arrives while an operation is in flight abandons that operation. The reset raises a flag, and the flag tells system software to program those words again.

Top module: `pgm_suspend_ctrl`

## Requirements
- R1: Mode encoding is 0 idle, 1 running, 2 suspended, 3 auto-select, 4 extended block. A `pgm_start` in idle enters running one cycle later and captures `pgm_blk`. `pgm_en` is high exactly in running. `pgm_done` in running returns to idle and takes priority over a suspend command in the same cycle.
- R2: The suspend code B0h moves running to suspended. It is ignored in idle.
- R3: The resume code 30h moves suspended back to running.
- R4: A resume code received while running is ignored. A further B0h after a resume is accepted again.
- R5: In suspended mode, any code other than 30h, 90h or 88h leaves the mode unchanged.
- R6: Code 90h in suspended mode enters auto-select, and `rd_asel` is high only there. Code F0h returns to suspended, not to idle. All other codes, including 30h, are ignored in auto-select.
- R7: Code 88h in suspended mode enters extended-block mode, and `rd_ext` is high only there. Code F0h returns to suspended. Outside this mode, reads go to the main array (`rd_ext` low).
- R8: `rd_ok` is low while running. In modes 2 to 4 it is low when `rd_blk` equals the captured program block. It is low whenever `erase_susp` is high and `rd_blk` equals `erase_blk`. Otherwise it is high.
- R9: `dev_reset` in any mode other than idle returns to idle one cycle later and sets `reprog`. The next accepted `pgm_start` clears `reprog`. A `pgm_start` outside idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| cmd_valid | input | 1 | A decoded command code is present |
| cmd_code | input | CMD_W | Command code |
| dev_reset | input | 1 | Device reset pulse; aborts an operation in flight |
| pgm_start | input | 1 | Engine begins a program operation |
| pgm_blk | input | BLK_W | Block address of the program operation |
| pgm_done | input | 1 | Engine finished the program operation |
| erase_susp | input | 1 | An erase is currently suspended |
| erase_blk | input | BLK_W | Block address of the suspended erase |
| rd_blk | input | BLK_W | Block address of the current read |
| mode | output | 3 | Current mode |
| pgm_en | output | 1 | Enable to the programming engine |
| rd_ok | output | 1 | Read at `rd_blk` is permitted |
| rd_asel | output | 1 | Reads return auto-select codes |
| rd_ext | output | 1 | Reads map to the extended block |
| reprog | output | 1 | The last operation was aborted by reset |

## Verification
The bench sends a resume to a controller that is already running. A design that does not ignore that resume would fall back to idle or re-enter suspended. It then sends F0h from auto-select and checks that the mode returns to suspended; a design that treats F0h as a full reset would drop to idle and lose the suspended program. Done and suspend are applied in the same cycle, which exposes a design with the wrong priority. A nested case with an erase also suspended checks that reads are refused in both blocks and granted next to them. The last check applies a reset while suspended and then looks at `reprog`, both when it should be set and after a new start has cleared it.

// File: rtl/pgm_suspend_ctrl.sv
module pgm_suspend_ctrl #(
  parameter int BLK_W = 15,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] C_SUSPEND = 8'hB0,
  parameter logic [CMD_W-1:0] C_RESUME  = 8'h30,
  parameter logic [CMD_W-1:0] C_ASEL    = 8'h90,
  parameter logic [CMD_W-1:0] C_EXT     = 8'h88,
  parameter logic [CMD_W-1:0] C_RDRST   = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             dev_reset,
  input  logic             pgm_start,
  input  logic [BLK_W-1:0] pgm_blk,
  input  logic             pgm_done,
  input  logic             erase_susp,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [2:0]       mode,
  output logic             pgm_en,
  output logic             rd_ok,
  output logic             rd_asel,
  output logic             rd_ext,
  output logic             reprog
);
  localparam logic [2:0] M_IDLE = 3'd0, M_RUN = 3'd1, M_SUSP = 3'd2,
                         M_ASEL = 3'd3, M_EXT = 3'd4;

  logic [2:0]       mode_q, mode_d;
  logic [BLK_W-1:0] blk_q;
  logic             reprog_q;
  logic             start_ok, held;

  assign start_ok = (mode_q == M_IDLE) && pgm_start && !dev_reset;
  assign held     = (mode_q == M_SUSP) || (mode_q == M_ASEL) || (mode_q == M_EXT);

  always_comb begin
    mode_d = mode_q;
    if (dev_reset) mode_d = M_IDLE;
    else case (mode_q)
      M_IDLE: if (pgm_start) mode_d = M_RUN;
      M_RUN: begin
        if (pgm_done) mode_d = M_IDLE;
        else if (cmd_valid && cmd_code == C_SUSPEND) mode_d = M_SUSP;
      end
      M_SUSP: if (cmd_valid) begin
        if (cmd_code == C_RESUME)    mode_d = M_RUN;
        else if (cmd_code == C_ASEL) mode_d = M_ASEL;
        else if (cmd_code == C_EXT)  mode_d = M_EXT;
      end
      M_ASEL, M_EXT: if (cmd_valid && cmd_code == C_RDRST) mode_d = M_SUSP;
      default: mode_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      blk_q    <= '0;
      reprog_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (start_ok) blk_q <= pgm_blk;
      if (dev_reset && mode_q != M_IDLE) reprog_q <= 1'b1;
      else if (start_ok) reprog_q <= 1'b0;
    end
  end

  assign mode    = mode_q;
  assign pgm_en  = (mode_q == M_RUN);
  assign rd_asel = (mode_q == M_ASEL);
  assign rd_ext  = (mode_q == M_EXT);
  assign reprog  = reprog_q;
  assign rd_ok   = (mode_q != M_RUN) && !(held && rd_blk == blk_q)
                   && !(erase_susp && rd_blk == erase_blk);

  // R1: done wins over a same-cycle suspend
  p_done_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && pgm_done && !dev_reset) |=> (mode_q == M_IDLE));
  // R2: suspend ignored while idle
  p_susp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !pgm_start && cmd_valid && cmd_code == C_SUSPEND) |=> (mode_q == M_IDLE));
  // R3: resume restarts programming
  p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP && cmd_valid && cmd_code == C_RESUME && !dev_reset) |=> pgm_en);
  // R4: extra resume while running changes nothing
  p_resume_ign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !pgm_done && !dev_reset && cmd_valid && cmd_code == C_RESUME) |=> (mode_q == M_RUN));
  // R6: leaving auto-select lands in suspended
  p_asel_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ASEL && !dev_reset && cmd_valid && cmd_code == C_RDRST) |=> (mode_q == M_SUSP));
  // R8: suspended block never readable
  p_rd_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held && rd_blk == blk_q) |-> !rd_ok);
  // R9: reset abort sets the flag
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_reset && mode_q != M_IDLE) |=> (mode_q == M_IDLE && reprog_q));
endmodule

// File: tb/tb_pgm_suspend_ctrl.sv
module tb_pgm_suspend_ctrl;
  localparam int BW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, dev_reset = 0, pgm_start = 0, pgm_done = 0, erase_susp = 0;
  logic [7:0] cmd_code = '0;
  logic [BW-1:0] pgm_blk = '0, erase_blk = '0, rd_blk = '0;
  logic [2:0] mode;
  logic pgm_en, rd_ok, rd_asel, rd_ext, reprog;
  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  int   q_mode[$];
  int   q_flag[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  pgm_suspend_ctrl #(.BLK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dev_reset(dev_reset), .pgm_start(pgm_start), .pgm_blk(pgm_blk),
    .pgm_done(pgm_done), .erase_susp(erase_susp), .erase_blk(erase_blk),
    .rd_blk(rd_blk), .mode(mode), .pgm_en(pgm_en), .rd_ok(rd_ok),
    .rd_asel(rd_asel), .rd_ext(rd_ext), .reprog(reprog));

  // monitor: pops expected mode/flag and compares
  always @(negedge clk) begin
    if (q_mode.size() > 0) begin
      int em, ef; string t;
      em = q_mode.pop_front(); ef = q_flag.pop_front(); t = q_tag.pop_front();
      n_cmp++;
      if (mode != em[2:0] || reprog != ef[0] || pgm_en != (em == 1) ||
          rd_asel != (em == 3) || rd_ext != (em == 4)) begin
        n_bad++;
        $display("FAIL %s: mode=%0d reprog=%0d pgm_en=%0d asel=%0d ext=%0d expected mode=%0d reprog=%0d",
                 t, mode, reprog, pgm_en, rd_asel, rd_ext, em, ef);
      end
    end
  end

  task automatic step(input logic v, input logic [7:0] c, input logic st,
                      input logic dn, input logic rs, input int em, input int ef, input string t);
    @(negedge clk);
    cmd_valid = v; cmd_code = c; pgm_start = st; pgm_done = dn; dev_reset = rs;
    @(posedge clk);
    q_mode.push_back(em); q_flag.push_back(ef); q_tag.push_back(t);
    #1;
    cmd_valid = 0; pgm_start = 0; pgm_done = 0; dev_reset = 0;
  endtask

  task automatic chk_rd(input logic [BW-1:0] b, input logic exp, input string t);
    @(negedge clk);
    rd_blk = b;
    #1;
    n_cmp++;
    if (rd_ok != exp) begin
      n_bad++;
      $display("FAIL %s: rd_ok=%0d expected %0d", t, rd_ok, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        rst_n = 1;
        step(0, 8'h00, 0, 0, 0, 0, 0, "R1 reset state");
        step(1, 8'hB0, 0, 0, 0, 0, 0, "R2 suspend ignored in idle");
        pgm_blk = 8'h12;
        step(0, 8'h00, 1, 0, 0, 1, 0, "R1 start enters running");
        chk_rd(8'h55, 0, "R8 no reads while running");
        step(1, 8'hB0, 0, 0, 0, 2, 0, "R2 suspend accepted");
        chk_rd(8'h12, 0, "R8 program block blocked");
        chk_rd(8'h13, 1, "R8 other block readable");
        step(1, 8'hA0, 0, 0, 0, 2, 0, "R5 foreign code ignored");
        step(1, 8'hF0, 0, 0, 0, 2, 0, "R5 read/reset keeps suspend");
        step(1, 8'h90, 0, 0, 0, 3, 0, "R6 enter auto-select");
        step(1, 8'h30, 0, 0, 0, 3, 0, "R6 resume ignored in auto-select");
        step(1, 8'hF0, 0, 0, 0, 2, 0, "R6 exit back to suspend");
        step(1, 8'h88, 0, 0, 0, 4, 0, "R7 enter extended block");
        step(1, 8'hF0, 0, 0, 0, 2, 0, "R7 exit back to suspend");
        step(1, 8'h30, 0, 0, 0, 1, 0, "R3 resume restarts");
        step(1, 8'h30, 0, 0, 0, 1, 0, "R4 second resume ignored");
        step(1, 8'hB0, 0, 0, 0, 2, 0, "R4 re-suspend accepted");
        step(1, 8'h30, 0, 0, 0, 1, 0, "R3 resume again");
        step(0, 8'h00, 0, 1, 0, 0, 0, "R1 done returns idle");
        erase_susp = 1; erase_blk = 8'h40; pgm_blk = 8'h41;
        step(0, 8'h00, 1, 0, 0, 1, 0, "R1 start nested");
        step(1, 8'hB0, 0, 0, 0, 2, 0, "R2 suspend over erase suspend");
        chk_rd(8'h40, 0, "R8 erase block blocked");
        chk_rd(8'h41, 0, "R8 program block blocked nested");
        chk_rd(8'h42, 1, "R8 neighbour readable nested");
        step(0, 8'h00, 1, 0, 0, 2, 0, "R9 start ignored while suspended");
        step(0, 8'h00, 0, 0, 1, 0, 1, "R9 reset aborts suspend");
        chk_rd(8'h41, 1, "R8 idle program block readable");
        step(0, 8'h00, 1, 0, 0, 1, 0, "R9 new start clears flag");
        step(1, 8'hB0, 0, 1, 0, 0, 0, "R1 done beats suspend");
        step(0, 8'h00, 0, 0, 0, 0, 0, "R1 idle settles");
        @(negedge clk); @(negedge clk);
        done_flag = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
          n_bad++;
          $display("FAIL watchdog: run hung, expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule